// File: doc/BRIEF.md
# Serial Bus Host Register Interface

This block is the software-visible front of a two-wire serial bus master. A host reaches it over a plain 32-bit register bus, where a write takes effect at the next clock edge and a read returns data in the same cycle. The block keeps the configuration the serial engine needs:
- clock control
- line control
- target register address
- data
- command
- runtime and hardware device addresses
- device-mode setup

Control writes become single-cycle start, abort and init pulses toward the engine. A soft reset holds the engine in reset for a fixed window.

Engine completion and error events are latched as sticky status bits, which the host clears by writing ones. Error events carry a 4-bit per-byte detail field and an acknowledge-error flag. A start issued while a transfer is still running does not disturb that transfer; it only raises a load-busy flag. One level-sensitive interrupt line combines the enabled status bits under a global enable. When a read transfer finishes with valid data, the received word replaces the data register.

Top module: `sbh_host_regs`

## Requirements
- R1: After rst_ni deasserts, every register reads 0, irq_o is low and all engine pulses are low.
- R2: Writing control (offset 0x00) with bit 7 set while idle gives eng_start_o high for exactly one cycle. Control bit 7 then reads 1 until eng_done_i or eng_err_i ends the transfer.
- R3: Writing control bit 7 while a transfer is running gives no start pulse, keeps the transfer busy and sets status (offset 0x0C) bit 2.
- R4: eng_done_i during a transfer sets status bit 0. eng_err_i during a transfer sets status bit 1, loads eng_err_data_i into status bits 11:8 and loads eng_err_ack_i into status bit 16.
- R5: Writing 1 to a status bit clears it. A write to bit 1 also clears the detail field in bits 11:8. Writing 0 leaves a bit unchanged.
- R6: irq_o is high exactly when control bit 1 (global enable) is set and some status bit among 2:0 is set whose enable bit, at the same position of offset 0x08, is also set.
- R7: Writing control bit 6 gives eng_abort_o for one cycle, ends the busy state and sets no status bit.
- R8: Writing control bit 0 starts a soft reset lasting SRST_CYCLES cycles. During the reset, control bit 0 reads 1, eng_srst_o is high and host writes are ignored. The reset returns every register, status and busy state to 0, and control bit 0 then clears itself.
- R9: Writing device-mode (offset 0x28) with bit 31 set gives eng_init_o for one cycle. Bit 31 reads 1 until eng_init_done_i, and bits 30:0 are stored.
- R10: When eng_done_i and eng_rvalid_i are high together during a transfer, the data register (offset 0x1C) takes eng_rdata_i.
- R11: The following registers read back their written fields and drive the matching config outputs:
  - clock control at 0x04, bits 10:0
  - interrupt enable at 0x08, bits 2:0
  - address at 0x10, bits 7:0
  - data at 0x1C, 32 bits
  - command at 0x2C, bits 7:0
  - device address at 0x30, runtime address in bits 23:16 and hardware address in bits 15:0
- R12: Line control (offset 0x24) stores bits 3:0. Reads return line_i[1] (clock line) in bit 5 and line_i[0] (data line) in bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | AW | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle |
| irq_o | output | 1 | Interrupt request, level |
| eng_start_o | output | 1 | Start a transfer, one-cycle pulse |
| eng_abort_o | output | 1 | Abort the transfer, one-cycle pulse |
| eng_srst_o | output | 1 | Engine reset, high during soft reset |
| eng_init_o | output | 1 | Start the device-mode sequence, one-cycle pulse |
| eng_done_i | input | 1 | Transfer finished |
| eng_err_i | input | 1 | Transfer failed |
| eng_err_data_i | input | 4 | Per-byte error detail |
| eng_err_ack_i | input | 1 | Acknowledge error flag |
| eng_rvalid_i | input | 1 | eng_rdata_i is valid along with eng_done_i |
| eng_rdata_i | input | 32 | Received data |
| eng_init_done_i | input | 1 | Device-mode sequence finished |
| line_i | input | 2 | Live line levels: [1] clock, [0] data |
| clk_cfg_o | output | 11 | Clock control field |
| line_ctl_o | output | 4 | Line control field |
| mode_cfg_o | output | 31 | Device-mode field |
| reg_addr_o | output | 8 | Target register address |
| wr_data_o | output | 32 | Data register |
| cmd_o | output | 8 | Command code |
| rt_addr_o | output | 8 | Runtime device address |
| hw_addr_o | output | 16 | Hardware device address |

## Verification
The bench builds the block with AW = 8 and SRST_CYCLES = 3. With a reset window this short, a host read can land inside the window and see control bit 0 and eng_srst_o high. A few idle cycles later, the bench confirms that the bit has cleared itself and that every register has returned to 0. AW = 8 covers every offset up to 0x30.

// File: rtl/sbh_pkg.sv
package sbh_pkg;
  localparam int unsigned OFS_CTRL = 'h00;
  localparam int unsigned OFS_CCR  = 'h04;
  localparam int unsigned OFS_INTE = 'h08;
  localparam int unsigned OFS_STAT = 'h0C;
  localparam int unsigned OFS_ADDR = 'h10;
  localparam int unsigned OFS_DATA = 'h1C;
  localparam int unsigned OFS_LCR  = 'h24;
  localparam int unsigned OFS_DM   = 'h28;
  localparam int unsigned OFS_CMD  = 'h2C;
  localparam int unsigned OFS_DAR  = 'h30;

  localparam int unsigned B_START = 7;
  localparam int unsigned B_ABORT = 6;
  localparam int unsigned B_GIE   = 1;
  localparam int unsigned B_SRST  = 0;
  localparam int unsigned B_DMGO  = 31;
  localparam int unsigned B_ACK   = 16;

  localparam int unsigned CCR_W  = 11;
  localparam int unsigned LCR_W  = 4;
  localparam int unsigned EDAT_W = 4;
  localparam int unsigned IRQ_N  = 3;

  typedef struct packed {
    logic                ack_err;
    logic [EDAT_W-1:0]   err_data;
    logic                load_busy;
    logic                trans_err;
    logic                trans_over;
  } sbh_stat_t;
endpackage

// File: rtl/sbh_ctrl.sv
module sbh_ctrl #(
  parameter int unsigned SRST_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_we_i,
  input  logic go_bit_i,
  input  logic abort_bit_i,
  input  logic gie_bit_i,
  input  logic srst_bit_i,
  input  logic dm_we_i,
  input  logic dm_go_i,
  input  logic init_done_i,
  input  logic xfer_end_i,
  output logic busy_o,
  output logic gie_o,
  output logic srst_o,
  output logic start_o,
  output logic abort_o,
  output logic init_o,
  output logic init_busy_o,
  output logic lbsy_set_o
);
  localparam int unsigned CW = (SRST_CYCLES < 2) ? 1 : $clog2(SRST_CYCLES);

  logic [CW-1:0] cnt_q;

  // start attempt while busy; reset and abort take precedence
  assign lbsy_set_o = ctrl_we_i && go_bit_i && busy_o && !srst_bit_i && !abort_bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o      <= 1'b0;
      gie_o       <= 1'b0;
      srst_o      <= 1'b0;
      start_o     <= 1'b0;
      abort_o     <= 1'b0;
      init_o      <= 1'b0;
      init_busy_o <= 1'b0;
      cnt_q       <= '0;
    end else begin
      start_o <= 1'b0;
      abort_o <= 1'b0;
      init_o  <= 1'b0;
      if (srst_o) begin
        if (cnt_q == '0) srst_o <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end else if (ctrl_we_i && srst_bit_i) begin
        srst_o      <= 1'b1;
        cnt_q       <= CW'(SRST_CYCLES - 1);
        busy_o      <= 1'b0;
        gie_o       <= 1'b0;
        init_busy_o <= 1'b0;
      end else begin
        if (ctrl_we_i) gie_o <= gie_bit_i;
        if (ctrl_we_i && abort_bit_i) begin
          busy_o  <= 1'b0;
          abort_o <= 1'b1;
        end else if (ctrl_we_i && go_bit_i && !busy_o) begin
          busy_o  <= 1'b1;
          start_o <= 1'b1;
        end else if (xfer_end_i) begin
          busy_o <= 1'b0;
        end
        if (dm_we_i && dm_go_i && !init_busy_o) begin
          init_busy_o <= 1'b1;
          init_o      <= 1'b1;
        end else if (init_done_i) begin
          init_busy_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sbh_status.sv
module sbh_status
  import sbh_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_all_i,
  input  logic              w1c_we_i,
  input  logic              w1c_over_i,
  input  logic              w1c_err_i,
  input  logic              w1c_lbsy_i,
  input  logic              w1c_ack_i,
  input  logic              lbsy_set_i,
  input  logic              done_i,
  input  logic              err_i,
  input  logic [EDAT_W-1:0] err_data_i,
  input  logic              err_ack_i,
  input  logic [IRQ_N-1:0]  inte_i,
  input  logic              gie_i,
  output sbh_stat_t         stat_o,
  output logic              irq_o
);
  sbh_stat_t st_d;

  always_comb begin
    st_d = stat_o;
    if (w1c_we_i) begin
      if (w1c_over_i) st_d.trans_over = 1'b0;
      if (w1c_err_i) begin
        st_d.trans_err = 1'b0;
        st_d.err_data  = '0;
      end
      if (w1c_lbsy_i) st_d.load_busy = 1'b0;
      if (w1c_ack_i)  st_d.ack_err   = 1'b0;
    end
    // new events win over a same-cycle clear
    if (lbsy_set_i) st_d.load_busy  = 1'b1;
    if (done_i)     st_d.trans_over = 1'b1;
    if (err_i) begin
      st_d.trans_err = 1'b1;
      st_d.err_data  = err_data_i;
      st_d.ack_err   = err_ack_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        stat_o <= '0;
    else if (clr_all_i) stat_o <= '0;
    else                stat_o <= st_d;
  end

  assign irq_o = gie_i &&
                 |({stat_o.load_busy, stat_o.trans_err, stat_o.trans_over} & inte_i);
endmodule

// File: rtl/sbh_host_regs.sv
module sbh_host_regs
  import sbh_pkg::*;
#(
  parameter int unsigned AW          = 8,
  parameter int unsigned SRST_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              eng_start_o,
  output logic              eng_abort_o,
  output logic              eng_srst_o,
  output logic              eng_init_o,
  input  logic              eng_done_i,
  input  logic              eng_err_i,
  input  logic [EDAT_W-1:0] eng_err_data_i,
  input  logic              eng_err_ack_i,
  input  logic              eng_rvalid_i,
  input  logic [31:0]       eng_rdata_i,
  input  logic              eng_init_done_i,
  input  logic [1:0]        line_i,
  output logic [CCR_W-1:0]  clk_cfg_o,
  output logic [LCR_W-1:0]  line_ctl_o,
  output logic [30:0]       mode_cfg_o,
  output logic [7:0]        reg_addr_o,
  output logic [31:0]       wr_data_o,
  output logic [7:0]        cmd_o,
  output logic [7:0]        rt_addr_o,
  output logic [15:0]       hw_addr_o
);
  logic       busy, gie, srst_act, init_busy, lbsy_set, we_ok, clr;
  logic       sel_ctrl, sel_stat, sel_dm;
  sbh_stat_t  stat;
  logic [IRQ_N-1:0] inte_q;

  assign we_ok    = req_i && we_i && !srst_act;
  assign sel_ctrl = we_ok && (addr_i == AW'(OFS_CTRL));
  assign sel_stat = we_ok && (addr_i == AW'(OFS_STAT));
  assign sel_dm   = we_ok && (addr_i == AW'(OFS_DM));
  assign clr      = srst_act || (sel_ctrl && wdata_i[B_SRST]);

  sbh_ctrl #(.SRST_CYCLES(SRST_CYCLES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_we_i   (sel_ctrl),
    .go_bit_i    (wdata_i[B_START]),
    .abort_bit_i (wdata_i[B_ABORT]),
    .gie_bit_i   (wdata_i[B_GIE]),
    .srst_bit_i  (wdata_i[B_SRST]),
    .dm_we_i     (sel_dm),
    .dm_go_i     (wdata_i[B_DMGO]),
    .init_done_i (eng_init_done_i),
    .xfer_end_i  (eng_done_i || eng_err_i),
    .busy_o      (busy),
    .gie_o       (gie),
    .srst_o      (srst_act),
    .start_o     (eng_start_o),
    .abort_o     (eng_abort_o),
    .init_o      (eng_init_o),
    .init_busy_o (init_busy),
    .lbsy_set_o  (lbsy_set)
  );

  sbh_status u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_all_i  (clr),
    .w1c_we_i   (sel_stat),
    .w1c_over_i (wdata_i[0]),
    .w1c_err_i  (wdata_i[1]),
    .w1c_lbsy_i (wdata_i[2]),
    .w1c_ack_i  (wdata_i[B_ACK]),
    .lbsy_set_i (lbsy_set),
    .done_i     (eng_done_i && busy),
    .err_i      (eng_err_i && busy),
    .err_data_i (eng_err_data_i),
    .err_ack_i  (eng_err_ack_i),
    .inte_i     (inte_q),
    .gie_i      (gie),
    .stat_o     (stat),
    .irq_o      (irq_o)
  );

  assign eng_srst_o = srst_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_cfg_o  <= '0;
      inte_q     <= '0;
      reg_addr_o <= '0;
      wr_data_o  <= '0;
      line_ctl_o <= '0;
      mode_cfg_o <= '0;
      cmd_o      <= '0;
      rt_addr_o  <= '0;
      hw_addr_o  <= '0;
    end else if (clr) begin
      clk_cfg_o  <= '0;
      inte_q     <= '0;
      reg_addr_o <= '0;
      wr_data_o  <= '0;
      line_ctl_o <= '0;
      mode_cfg_o <= '0;
      cmd_o      <= '0;
      rt_addr_o  <= '0;
      hw_addr_o  <= '0;
    end else begin
      if (we_ok) begin
        if (addr_i == AW'(OFS_CCR))  clk_cfg_o  <= wdata_i[CCR_W-1:0];
        if (addr_i == AW'(OFS_INTE)) inte_q     <= wdata_i[IRQ_N-1:0];
        if (addr_i == AW'(OFS_ADDR)) reg_addr_o <= wdata_i[7:0];
        if (addr_i == AW'(OFS_LCR))  line_ctl_o <= wdata_i[LCR_W-1:0];
        if (addr_i == AW'(OFS_DM))   mode_cfg_o <= wdata_i[30:0];
        if (addr_i == AW'(OFS_CMD))  cmd_o      <= wdata_i[7:0];
        if (addr_i == AW'(OFS_DAR)) begin
          rt_addr_o <= wdata_i[23:16];
          hw_addr_o <= wdata_i[15:0];
        end
      end
      // received data has priority over a host write
      if (eng_done_i && busy && eng_rvalid_i)         wr_data_o <= eng_rdata_i;
      else if (we_ok && addr_i == AW'(OFS_DATA))      wr_data_o <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      AW'(OFS_CTRL): rdata_o = {24'b0, busy, 5'b0, gie, srst_act};
      AW'(OFS_CCR):  rdata_o = {{(32-CCR_W){1'b0}}, clk_cfg_o};
      AW'(OFS_INTE): rdata_o = {{(32-IRQ_N){1'b0}}, inte_q};
      AW'(OFS_STAT): rdata_o = {15'b0, stat.ack_err, 4'b0, stat.err_data, 5'b0,
                                stat.load_busy, stat.trans_err, stat.trans_over};
      AW'(OFS_ADDR): rdata_o = {24'b0, reg_addr_o};
      AW'(OFS_DATA): rdata_o = wr_data_o;
      AW'(OFS_LCR):  rdata_o = {26'b0, line_i, line_ctl_o};
      AW'(OFS_DM):   rdata_o = {init_busy, mode_cfg_o};
      AW'(OFS_CMD):  rdata_o = {24'b0, cmd_o};
      AW'(OFS_DAR):  rdata_o = {8'b0, rt_addr_o, hw_addr_o};
      default:       rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sbh_host_regs_chk.sv
module sbh_host_regs_chk
  import sbh_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      start_i,
  input logic      abort_i,
  input logic      srst_i,
  input logic      init_i,
  input logic      busy_i,
  input logic      gie_i,
  input logic      irq_i,
  input logic      init_busy_i,
  input sbh_stat_t stat_i
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !start_i); // R2
  AST_START_RAISES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> $rose(busy_i)); // R2
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_i) |-> !start_i); // R3
  AST_ABORT_DROPS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |-> !busy_i); // R7
  AST_SRST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |-> (!busy_i && stat_i == '0 && !irq_i)); // R8
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> gie_i); // R6
  AST_INIT_RAISES_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |-> $rose(init_busy_i)); // R9
endmodule

bind sbh_host_regs sbh_host_regs_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (eng_start_o),
  .abort_i     (eng_abort_o),
  .srst_i      (eng_srst_o),
  .init_i      (eng_init_o),
  .busy_i      (busy),
  .gie_i       (gie),
  .irq_i       (irq_o),
  .init_busy_i (init_busy),
  .stat_i      (stat)
);

// File: tb/sim_sbh_host_regs.sv
`timescale 1ns/1ps
module sim_sbh_host_regs;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, st, ab, sr, in;
  logic        done = 1'b0, err = 1'b0, ack = 1'b0, rvalid = 1'b0, idone = 1'b0;
  logic [3:0]  edat = '0;
  logic [31:0] rdat = '0;
  logic [1:0]  line = 2'b10;
  logic [10:0] ccr_o;
  logic [3:0]  lcr_o;
  logic [30:0] mode_o;
  logic [7:0]  radr_o, cmd_o, rta_o;
  logic [31:0] wd_o;
  logic [15:0] hwa_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          finished = 0;

  always #2.5 clk = ~clk;

  sbh_host_regs #(.AW(8), .SRST_CYCLES(3)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .eng_start_o(st), .eng_abort_o(ab), .eng_srst_o(sr), .eng_init_o(in),
    .eng_done_i(done), .eng_err_i(err), .eng_err_data_i(edat), .eng_err_ack_i(ack),
    .eng_rvalid_i(rvalid), .eng_rdata_i(rdat), .eng_init_done_i(idone), .line_i(line),
    .clk_cfg_o(ccr_o), .line_ctl_o(lcr_o), .mode_cfg_o(mode_o), .reg_addr_o(radr_o),
    .wr_data_o(wd_o), .cmd_o(cmd_o), .rt_addr_o(rta_o), .hw_addr_o(hwa_o)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string t);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", t, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  // driver: pushes the expected word, monitor compares it
  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); req = 1'b0;
  endtask

  task automatic eng_done(input logic v, input logic [31:0] d);
    @(negedge clk); done = 1'b1; rvalid = v; rdat = d;
    @(negedge clk); done = 1'b0; rvalid = 1'b0;
  endtask

  task automatic eng_err(input logic [3:0] e, input logic a);
    @(negedge clk); err = 1'b1; edat = e; ack = a;
    @(negedge clk); err = 1'b0; edat = '0; ack = 1'b0;
  endtask

  // monitor
  initial forever begin
    @(negedge clk); #1;
    if (req && !we && exp_q.size() > 0) chk(rdata, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    chk({28'b0, irq, st, ab, sr}, 32'h0, "R1 pins after reset");
    chk({31'b0, in}, 32'h0, "R1 init pin after reset");
    rd(8'h00, 32'h0, "R1 ctrl");
    rd(8'h0C, 32'h0, "R1 stat");
    rd(8'h1C, 32'h0, "R1 data");
    rd(8'h30, 32'h0, "R1 dar");
    // R11 config readback
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h7FF, "R11 ccr");
    chk({21'b0, ccr_o}, 32'h7FF, "R11 clk_cfg_o");
    wr(8'h10, 32'h1A5); rd(8'h10, 32'hA5, "R11 addr");
    wr(8'h30, 32'h122D_03A3); rd(8'h30, 32'h002D_03A3, "R11 dar");
    chk({8'b0, rta_o, hwa_o}, 32'h002D_03A3, "R11 rt/hw addr outputs");
    wr(8'h2C, 32'h8B); rd(8'h2C, 32'h8B, "R11 cmd");
    chk({24'b0, cmd_o}, 32'h8B, "R11 cmd_o");
    wr(8'h1C, 32'h1234_5678); rd(8'h1C, 32'h1234_5678, "R11 data");
    // R12 line control
    wr(8'h24, 32'hFF); rd(8'h24, 32'h2F, "R12 lcr with line 10");
    line = 2'b01; rd(8'h24, 32'h1F, "R12 lcr with line 01");
    // R2 start
    wr(8'h08, 32'h7);
    wr(8'h00, 32'h82);
    chk({31'b0, st}, 32'h1, "R2 start pulse");
    @(negedge clk); chk({31'b0, st}, 32'h0, "R2 start one cycle");
    rd(8'h00, 32'h82, "R2 busy reads 1");
    chk({31'b0, irq}, 32'h0, "R6 irq low no status");
    // R3 load busy
    wr(8'h00, 32'h82);
    chk({31'b0, st}, 32'h0, "R3 no start while busy");
    rd(8'h0C, 32'h4, "R3 load busy flag");
    rd(8'h00, 32'h82, "R3 still busy");
    chk({31'b0, irq}, 32'h1, "R6 irq on load busy");
    // R5 W1C
    wr(8'h0C, 32'h0); rd(8'h0C, 32'h4, "R5 write 0 keeps");
    wr(8'h0C, 32'h4); rd(8'h0C, 32'h0, "R5 write 1 clears");
    chk({31'b0, irq}, 32'h0, "R6 irq drops after clear");
    // R4/R10 done with read data
    eng_done(1'b1, 32'hDEAD_BEEF);
    rd(8'h0C, 32'h1, "R4 transfer over");
    rd(8'h1C, 32'hDEAD_BEEF, "R10 received data");
    rd(8'h00, 32'h02, "R2 busy ends on done");
    chk({31'b0, irq}, 32'h1, "R6 irq on done");
    wr(8'h08, 32'h6); @(negedge clk);
    chk({31'b0, irq}, 32'h0, "R6 masked by enable");
    wr(8'h08, 32'h7); wr(8'h00, 32'h00); @(negedge clk);
    chk({31'b0, irq}, 32'h0, "R6 masked by global enable");
    wr(8'h0C, 32'h1);
    // R4 error
    wr(8'h00, 32'h82);
    eng_err(4'hA, 1'b1);
    rd(8'h0C, 32'h0001_0A02, "R4 error detail");
    rd(8'h00, 32'h02, "R4 busy ends on error");
    wr(8'h0C, 32'h2); rd(8'h0C, 32'h0001_0000, "R5 clear err and detail");
    wr(8'h0C, 32'h1_0000); rd(8'h0C, 32'h0, "R5 clear ack");
    // R7 abort
    wr(8'h00, 32'h82);
    wr(8'h00, 32'h42);
    chk({31'b0, ab}, 32'h1, "R7 abort pulse");
    @(negedge clk); chk({31'b0, ab}, 32'h0, "R7 abort one cycle");
    rd(8'h00, 32'h02, "R7 busy cleared");
    rd(8'h0C, 32'h0, "R7 no status");
    // R9 device mode
    wr(8'h28, 32'h807C_3E00);
    chk({31'b0, in}, 32'h1, "R9 init pulse");
    rd(8'h28, 32'h807C_3E00, "R9 init pending");
    @(negedge clk); idone = 1'b1; @(negedge clk); idone = 1'b0;
    rd(8'h28, 32'h007C_3E00, "R9 init done");
    // R8 soft reset
    wr(8'h00, 32'h82); wr(8'h00, 32'h82);
    wr(8'h00, 32'h01);
    chk({31'b0, sr}, 32'h1, "R8 engine reset high");
    chk({31'b0, irq}, 32'h0, "R8 irq cleared");
    rd(8'h00, 32'h01, "R8 srst bit reads 1");
    repeat (4) @(negedge clk);
    chk({31'b0, sr}, 32'h0, "R8 engine reset released");
    rd(8'h00, 32'h0, "R8 ctrl self-cleared");
    rd(8'h0C, 32'h0, "R8 stat cleared");
    rd(8'h04, 32'h0, "R8 ccr cleared");
    rd(8'h30, 32'h0, "R8 dar cleared");
    rd(8'h1C, 32'h0, "R8 data cleared");
    repeat (3) @(negedge clk);
    summary();
  end
endmodule